// File: doc/BRIEF.md
# Glitch-free clock output gate

This block sits between a bank of generated clocks and their output pads. It decides, lane by lane, whether each clock is passed through, parked, or left undriven. Single-ended lanes carry one level and a drive enable. Differential lanes carry a true leg and a complement leg, and each leg has its own drive enable. Every generated clock arrives as a level that toggles in one fast sampling clock domain, and every output is a register in that domain. All `*_src` inputs and `pd_req` are assumed to be synchronous to `clk`.

Three controls act on the lanes. A per-lane output enable releases both legs to high impedance. A software run bit, together with a per-lane stoppable mask, halts the selected lanes. A power-down request parks every lane, but only after it has been confirmed at clean edges of a chosen reference lane. A lane is parked or released only at a source edge that cannot leave a shortened pulse behind. A single-ended lane stops on a falling edge and is held low. A differential lane stops on a rising edge of its true source, with the true leg held high. For the differential lanes, the park drive comes from one shared stop mode bit, or from a per-lane power-down mode bit when power-down is active.

Top module: `clkout_gate`

## Requirements
- R1: Power-down becomes active only after `pd_req` is sampled high at two consecutive falling edges of the true source of differential lane `PD_REF_LANE` (the rising edges of its complement). A request seen at only one such edge has no effect, and the first such edge that samples `pd_req` low releases power-down.
- R2: While power-down is active, each single-ended lane finishes its current high phase, goes low at the next falling edge of its source, and then stays low and driven.
- R3: While power-down is active, each differential lane parks at the next rising edge of its true source: the park shows one cycle after the clock edge that samples that rise, so a lane parks within one source period of qualification. From then on, the true leg is 1 and the complement leg is undriven.
- R4: During power-down, a differential lane whose `dif_pd_hiz` bit is 0 keeps its true leg driven high. A lane whose bit is 1 has both legs undriven.
- R5: When `sw_run` is 0, every lane whose stoppable bit is 1 parks at its own clean edge, as in R2 and R3. When `sw_run` returns to 1, those lanes restart.
- R6: A lane whose stoppable bit is 0 keeps toggling while `sw_run` is 0.
- R7: A differential lane parked only by the software stop uses `dif_stop_hiz`: 0 keeps the true leg driven high and 1 leaves both legs undriven. While power-down is active, the lane's `dif_pd_hiz` bit takes precedence.
- R8: An output enable of 0 clears both drive enables of that lane one cycle later, whatever the stop or power-down state.
- R9: No output ever shows a shortened pulse. A single-ended lane rejoins its source only while the source is low, so every high phase is a full source high phase. A differential lane rejoins only while its true source is high, so every low phase of the true leg is full.
- R10: While `rst` is high, every drive enable is 0, every single-ended level is 0, every true leg is 1 and every complement leg is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_req | input | 1 | Raw power-down request |
| sw_run | input | 1 | Software run bit; 0 halts stoppable lanes |
| se_src | input | N_SE | Source levels of single-ended lanes |
| se_oe | input | N_SE | Output enables of single-ended lanes |
| se_stoppable | input | N_SE | 1 = lane obeys the software stop |
| dif_src | input | N_DIF | True source levels of differential lanes |
| dif_oe | input | N_DIF | Output enables of differential lanes |
| dif_stoppable | input | N_DIF | 1 = lane obeys the software stop |
| dif_pd_hiz | input | N_DIF | Power-down park mode: 0 true driven high, 1 both undriven |
| dif_stop_hiz | input | 1 | Software-stop park mode for differential lanes |
| se_out | output | N_SE | Single-ended output levels |
| se_drv | output | N_SE | Single-ended drive enables |
| dif_t | output | N_DIF | True leg levels |
| dif_c | output | N_DIF | Complement leg levels |
| dif_t_drv | output | N_DIF | True leg drive enables |
| dif_c_drv | output | N_DIF | Complement leg drive enables |

## Verification
Every output is one register stage behind the sampled inputs, so an output-enable change is checked on the first sample after one rising edge. Power-down is due two cycles after the second qualifying reference edge: one cycle for the qualifier register and one for the lane register. The bench aligns the request to a known phase of the reference source and samples the complement drive on exactly the cycle before and the cycle after the expected park. Park and resume states that depend on when each source edge arrives are checked only after a settling wait of more than four source periods, over a window of two or more periods. A monitor that runs all the time measures every high phase of the single-ended lanes and every low phase of the true legs against the known source phase lengths, and reports any shortened pulse.

// File: rtl/clkg_pkg.sv
package clkg_pkg;

  typedef struct packed {
    logic t;
    logic c;
    logic t_drv;
    logic c_drv;
  } dif_pins_t;

endpackage

// File: rtl/clkg_pd_qual.sv
module clkg_pd_qual #(
  parameter int QUAL_SAMPLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_src,
  input  logic pd_raw,
  output logic pd_act
);
  localparam int CW = $clog2(QUAL_SAMPLES + 1);
  localparam logic [CW-1:0] QMAX = CW'(QUAL_SAMPLES);

  logic          ref_prev;
  logic [CW-1:0] hits;
  logic          ref_fall;

  assign ref_fall = ref_prev & ~ref_src;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_prev <= 1'b0;
      hits     <= '0;
      pd_act   <= 1'b0;
    end else begin
      ref_prev <= ref_src;
      if (ref_fall) begin
        if (!pd_raw)
          hits <= '0;
        else if (hits != QMAX)
          hits <= hits + 1'b1;
        pd_act <= pd_raw && (hits >= QMAX - 1'b1);
      end
    end
  end

  // R1: activation only at a reference edge that sampled the request high
  p_pd_qualified_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_act) |-> $past(pd_raw) && $past(ref_fall));

  // R1: release only at a reference edge that sampled the request low
  p_pd_release_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(pd_act) |-> !$past(pd_raw) && $past(ref_fall));

endmodule

// File: rtl/clkg_se_lane.sv
module clkg_se_lane (
  input  logic clk,
  input  logic rst,
  input  logic src,
  input  logic halt,
  input  logic oe,
  output logic out,
  output logic drv
);
  logic run_q;
  logic prev_q;
  logic park_now;
  logic wake_now;

  assign park_now = run_q & halt & prev_q & ~src;
  assign wake_now = ~run_q & ~halt & ~src;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      prev_q <= 1'b0;
      out    <= 1'b0;
      drv    <= 1'b0;
    end else begin
      prev_q <= src;
      if (park_now)
        run_q <= 1'b0;
      else if (wake_now)
        run_q <= 1'b1;
      out <= run_q & src;
      drv <= oe;
    end
  end

  // R8: disabled lane is undriven on the next cycle
  p_se_oe_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(oe) |-> !drv);

  // R2: output only falls following a low source sample
  p_se_fall_clean_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(out) |-> !$past(src));

  // R9: output only rises on a source rising edge (full high phase)
  p_se_full_high_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(out) |-> $past(src) && !$past(src, 2));

endmodule

// File: rtl/clkg_dif_lane.sv
module clkg_dif_lane
  import clkg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      src,
  input  logic      halt,
  input  logic      oe,
  input  logic      park_hiz,
  output dif_pins_t pins
);
  logic run_q;
  logic prev_q;
  logic park_now;
  logic wake_now;
  logic run_d;

  assign park_now = run_q & halt & ~prev_q & src;
  assign wake_now = ~run_q & ~halt & src;
  assign run_d    = park_now ? 1'b0 : (wake_now ? 1'b1 : run_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q      <= 1'b0;
      prev_q     <= 1'b0;
      pins.t     <= 1'b1;
      pins.c     <= 1'b0;
      pins.t_drv <= 1'b0;
      pins.c_drv <= 1'b0;
    end else begin
      prev_q     <= src;
      run_q      <= run_d;
      pins.t     <= src | ~run_d;
      pins.c     <= ~src & run_d;
      pins.t_drv <= oe & (run_d | ~park_hiz);
      pins.c_drv <= oe & run_d;
    end
  end

  // R8: disabled lane has both legs undriven on the next cycle
  p_dif_oe_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(oe) |-> !pins.t_drv && !pins.c_drv);

  // R4: a lone driven true leg is parked high
  p_dif_park_high_r4: assert property (@(posedge clk) disable iff (rst)
    pins.t_drv && !pins.c_drv |-> pins.t);

  // R3: true leg only falls after a low source sample
  p_dif_fall_clean_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(pins.t) |-> !$past(src));

  // R9: true leg only rises after a high source sample
  p_dif_rise_clean_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(pins.t) |-> $past(src));

endmodule

// File: rtl/clkout_gate.sv
module clkout_gate #(
  parameter int N_SE        = 11,
  parameter int N_DIF       = 10,
  parameter int PD_REF_LANE = 0,
  parameter int PD_QUAL     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pd_req,
  input  logic             sw_run,
  input  logic [N_SE-1:0]  se_src,
  input  logic [N_SE-1:0]  se_oe,
  input  logic [N_SE-1:0]  se_stoppable,
  input  logic [N_DIF-1:0] dif_src,
  input  logic [N_DIF-1:0] dif_oe,
  input  logic [N_DIF-1:0] dif_stoppable,
  input  logic [N_DIF-1:0] dif_pd_hiz,
  input  logic             dif_stop_hiz,
  output logic [N_SE-1:0]  se_out,
  output logic [N_SE-1:0]  se_drv,
  output logic [N_DIF-1:0] dif_t,
  output logic [N_DIF-1:0] dif_c,
  output logic [N_DIF-1:0] dif_t_drv,
  output logic [N_DIF-1:0] dif_c_drv
);
  logic pd_act;

  clkg_pd_qual #(.QUAL_SAMPLES(PD_QUAL)) u_pd_qual (
    .clk    (clk),
    .rst    (rst),
    .ref_src(dif_src[PD_REF_LANE]),
    .pd_raw (pd_req),
    .pd_act (pd_act)
  );

  for (genvar i = 0; i < N_SE; i++) begin : g_se
    logic lane_halt;
    assign lane_halt = pd_act | (se_stoppable[i] & ~sw_run);

    clkg_se_lane u_lane (
      .clk (clk),
      .rst (rst),
      .src (se_src[i]),
      .halt(lane_halt),
      .oe  (se_oe[i]),
      .out (se_out[i]),
      .drv (se_drv[i])
    );
  end

  for (genvar i = 0; i < N_DIF; i++) begin : g_dif
    logic                lane_halt;
    logic                lane_hiz;
    clkg_pkg::dif_pins_t lane_pins;

    assign lane_halt = pd_act | (dif_stoppable[i] & ~sw_run);
    assign lane_hiz  = pd_act ? dif_pd_hiz[i] : dif_stop_hiz;

    clkg_dif_lane u_lane (
      .clk     (clk),
      .rst     (rst),
      .src     (dif_src[i]),
      .halt    (lane_halt),
      .oe      (dif_oe[i]),
      .park_hiz(lane_hiz),
      .pins    (lane_pins)
    );

    assign dif_t[i]     = lane_pins.t;
    assign dif_c[i]     = lane_pins.c;
    assign dif_t_drv[i] = lane_pins.t_drv;
    assign dif_c_drv[i] = lane_pins.c_drv;
  end

endmodule

// File: tb/test_clkout_gate.sv
module test_clkout_gate;
  localparam int NS = 4;
  localparam int ND = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pd_req = 1'b0;
  logic sw_run = 1'b1;
  logic dif_stop_hiz = 1'b1;
  logic [NS-1:0] se_src = '0;
  logic [NS-1:0] se_oe = '1;
  logic [NS-1:0] se_stoppable = 4'b0011;
  logic [ND-1:0] dif_src = '0;
  logic [ND-1:0] dif_oe = '1;
  logic [ND-1:0] dif_stoppable = 3'b010;
  logic [ND-1:0] dif_pd_hiz = 3'b100;
  logic [NS-1:0] se_out, se_drv;
  logic [ND-1:0] dif_t, dif_c, dif_t_drv, dif_c_drv;

  clkout_gate #(.N_SE(NS), .N_DIF(ND), .PD_REF_LANE(0), .PD_QUAL(2)) i_clkout_gate (
    .clk(clk), .rst(rst), .pd_req(pd_req), .sw_run(sw_run),
    .se_src(se_src), .se_oe(se_oe), .se_stoppable(se_stoppable),
    .dif_src(dif_src), .dif_oe(dif_oe), .dif_stoppable(dif_stoppable),
    .dif_pd_hiz(dif_pd_hiz), .dif_stop_hiz(dif_stop_hiz),
    .se_out(se_out), .se_drv(se_drv), .dif_t(dif_t), .dif_c(dif_c),
    .dif_t_drv(dif_t_drv), .dif_c_drv(dif_c_drv)
  );

  always #2 clk = ~clk;  // 250 MHz

  int ph = 0;
  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;
  int runt_se = 0;
  int runt_dif = 0;
  int hi_len [NS];
  int lo_len [ND];
  bit arm_se [NS];
  bit arm_dif [ND];

  // Sources: single-ended 4 high / 4 low, differential 3 high / 3 low; glitch monitor
  always @(negedge clk) begin
    if (mon_on) begin
      for (int i = 0; i < NS; i++) begin
        if (!se_out[i]) begin
          if (arm_se[i] && hi_len[i] != 0 && hi_len[i] != 4) runt_se++;
          hi_len[i] = 0;
          arm_se[i] = 1'b1;
        end else begin
          hi_len[i]++;
        end
      end
      for (int i = 0; i < ND; i++) begin
        if (dif_t[i]) begin
          if (arm_dif[i] && lo_len[i] != 0 && lo_len[i] != 3) runt_dif++;
          lo_len[i] = 0;
          arm_dif[i] = 1'b1;
        end else begin
          lo_len[i]++;
        end
      end
    end
    ph = ph + 1;
    se_src  = {NS{((ph % 8) < 4)}};
    dif_src = {ND{((ph % 6) < 3)}};
  end

  logic [NS-1:0] se_hi, se_drv_and, se_drv_or;
  logic [ND-1:0] t_lo, t_drv_and, t_drv_or, c_drv_and, c_drv_or;

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic steps(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic watch(input int n);
    se_hi = '0; se_drv_and = '1; se_drv_or = '0;
    t_lo = '0; t_drv_and = '1; t_drv_or = '0; c_drv_and = '1; c_drv_or = '0;
    for (int k = 0; k < n; k++) begin
      step();
      se_hi      |= se_out;
      se_drv_and &= se_drv;
      se_drv_or  |= se_drv;
      t_lo       |= ~dif_t;
      t_drv_and  &= dif_t_drv;
      t_drv_or   |= dif_t_drv;
      c_drv_and  &= dif_c_drv;
      c_drv_or   |= dif_c_drv;
    end
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic align6();
    do step(); while ((ph % 6) != 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    steps(4);
    chk("R10", "se_out in reset", 32'(se_out), 32'h0);
    chk("R10", "se_drv in reset", 32'(se_drv), 32'h0);
    chk("R10", "dif_t in reset", 32'(dif_t), 32'h7);
    chk("R10", "dif_c in reset", 32'(dif_c), 32'h0);
    chk("R10", "dif drives in reset", 32'({dif_t_drv, dif_c_drv}), 32'h0);
    rst = 1'b0;
    steps(20);
    mon_on = 1'b1;
  endtask

  task automatic t_free_run();
    watch(24);
    chk("R8", "se lanes toggle", 32'(se_hi), 32'hF);
    chk("R8", "se lanes driven", 32'(se_drv_and), 32'hF);
    chk("R8", "true legs toggle", 32'(t_lo), 32'h7);
    chk("R8", "complement legs driven", 32'(c_drv_and), 32'h7);
  endtask

  task automatic t_pd_single();
    align6();
    pd_req = 1'b1;
    steps(6);
    pd_req = 1'b0;
    watch(30);
    chk("R1", "single sample ignored, se", 32'(se_hi), 32'hF);
    chk("R1", "single sample ignored, dif", 32'(t_lo), 32'h7);
  endtask

  task automatic t_pd_park();
    int base;
    align6();
    base = ph;
    pd_req = 1'b1;
    while (ph - base < 12) step();
    chk("R3", "ref lane complement before park", 32'(dif_c_drv[0]), 32'h1);
    step();
    chk("R3", "ref lane complement after park", 32'(dif_c_drv[0]), 32'h0);
    chk("R3", "ref lane true parked high", 32'(dif_t[0]), 32'h1);
    steps(30);
    watch(16);
    chk("R2", "se lanes held low", 32'(se_hi), 32'h0);
    chk("R2", "se lanes stay driven", 32'(se_drv_and), 32'hF);
    chk("R3", "true legs parked", 32'(t_lo), 32'h0);
    chk("R4", "true drive by pd mode", 32'(t_drv_or), 32'h3);
    chk("R4", "true drive steady", 32'(t_drv_and), 32'h3);
    chk("R4", "complements undriven", 32'(c_drv_or), 32'h0);
  endtask

  task automatic t_pd_release();
    pd_req = 1'b0;
    steps(30);
    watch(24);
    chk("R9", "se lanes resume", 32'(se_hi), 32'hF);
    chk("R9", "true legs resume", 32'(t_lo), 32'h7);
    chk("R9", "complements driven again", 32'(c_drv_and), 32'h7);
  endtask

  task automatic t_soft_stop();
    dif_stop_hiz = 1'b1;
    sw_run = 1'b0;
    steps(30);
    watch(16);
    chk("R5", "stoppable se lanes low", 32'(se_hi & 4'b0011), 32'h0);
    chk("R6", "free se lanes toggle", 32'(se_hi & 4'b1100), 32'hC);
    chk("R5", "stoppable dif lane parked", 32'(t_lo), 32'h5);
    chk("R7", "stop hiz true drive", 32'(t_drv_or), 32'h5);
    chk("R7", "stop hiz complement drive", 32'(c_drv_or), 32'h5);
    dif_stop_hiz = 1'b0;
    steps(4);
    watch(8);
    chk("R7", "stop driven true leg", 32'(t_drv_and), 32'h7);
    chk("R7", "stop driven complement", 32'(c_drv_or), 32'h5);
    dif_stop_hiz = 1'b1;
    pd_req = 1'b1;
    steps(40);
    watch(12);
    chk("R7", "pd mode overrides stop mode", 32'(t_drv_and), 32'h3);
    pd_req = 1'b0;
    steps(30);
    watch(12);
    chk("R7", "stop mode back after pd", 32'(t_drv_or), 32'h5);
    sw_run = 1'b1;
    steps(30);
    watch(24);
    chk("R5", "stopped se lanes resume", 32'(se_hi), 32'hF);
    chk("R5", "stopped dif lane resumes", 32'(t_lo), 32'h7);
  endtask

  task automatic t_oe();
    step();
    se_oe = 4'b0111;
    dif_oe = 3'b110;
    chk("R8", "se drive before edge", 32'(se_drv[3]), 32'h1);
    step();
    chk("R8", "se drive one cycle later", 32'(se_drv[3]), 32'h0);
    chk("R8", "dif drives one cycle later", 32'({dif_t_drv[0], dif_c_drv[0]}), 32'h0);
    pd_req = 1'b1;
    steps(40);
    watch(12);
    chk("R8", "se drive under pd", 32'(se_drv_or), 32'h7);
    chk("R8", "true drive under pd", 32'(t_drv_or), 32'h2);
    chk("R8", "complement drive under pd", 32'(c_drv_or), 32'h0);
    pd_req = 1'b0;
    se_oe = '1;
    dif_oe = '1;
    steps(30);
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_free_run();
    t_pd_single();
    t_pd_park();
    t_pd_release();
    t_soft_stop();
    t_oe();
    chk("R9", "no short se high phase", 32'(runt_se), 32'h0);
    chk("R9", "no short true low phase", 32'(runt_dif), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule